// File: doc/BRIEF.md
# Virtual Address Region and Permission Checker

This block sits in front of page table lookup. Each request carries a 32-bit virtual address, a read-or-write flag, the privilege mode of the requester and a 4-bit protection code for the target page. The block cuts the address into a 2-bit region selector, a 21-bit page number and a 9-bit byte offset within a 512-byte page. It then decides whether the request may go on to translation.

The page number is checked against the length limit of the selected region. The program region and the system region grow upward from their base. The control region grows downward from its top, so its limit works as a floor rather than a ceiling. The fourth region code is reserved and is never accepted. If the length check passes, the protection code is compared with the privilege mode and the access type.

One clock after an input strobe, the block returns the split fields, a length-fault flag, a permission-fault flag and a one-cycle valid pulse.

Top module: `vaddr_guard`

## Requirements
- R1: On a result, `out_offset` equals address bits 8:0 of the request and `out_vpn` equals address bits 29:9.
- R2: `out_region` equals address bits 31:30, coded 0 = program region, 1 = control region, 2 = system region, 3 = reserved.
- R3: For region 0 or region 2, `out_len_fault` is raised exactly when the page number is greater than or equal to that region's limit (`p0_len` or `sys_len`). A limit of 0 rejects every page.
- R4: For region 1, `out_len_fault` is raised exactly when the page number is less than `p1_len`. A limit of 0 accepts every page.
- R5: Region 3 always raises `out_len_fault`, whatever the limits, mode or protection code.
- R6: Modes are coded 0 = kernel, 1 = executive, 2 = supervisor, 3 = user, and `in_write` is 1 for a write. `in_prot[1:0]` holds the least privileged mode allowed to read and `in_prot[3:2]` holds the least privileged mode allowed to write. A read is allowed when mode <= `in_prot[1:0]`. A write is allowed when mode <= `in_prot[3:2]` and mode <= `in_prot[1:0]`. `out_acc_fault` is raised when the access is not allowed and the length check passed.
- R7: The length fault takes precedence: `out_len_fault` and `out_acc_fault` are never high together.
- R8: A request taken with `in_valid` high gives `out_valid` high for exactly the next cycle. Both fault flags are low whenever `out_valid` is low.
- R9: Synchronous reset forces `out_valid` and both fault flags low, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 32 | Virtual address |
| in_write | input | 1 | 1 = write, 0 = read |
| in_mode | input | 2 | Privilege mode of the requester |
| in_prot | input | 4 | Page protection code (write floor, read floor) |
| p0_len | input | 21 | Page limit of the program region |
| p1_len | input | 21 | Page floor of the control region |
| sys_len | input | 21 | Page limit of the system region |
| out_valid | output | 1 | One-cycle result strobe |
| out_region | output | 2 | Region selector of the request |
| out_vpn | output | 21 | Virtual page number |
| out_offset | output | 9 | Byte offset within the page |
| out_len_fault | output | 1 | Length violation |
| out_acc_fault | output | 1 | Permission violation |

## Verification
A length violation and a permission violation can arise from the same request. The bench provokes this with a sweep over every region, mode, protection code and access type. For each combination it uses page numbers just below, at and just above small limits, so many requests fail both checks at once. The bench computes each expected flag from the requirement arithmetic and checks that only the length flag appears on those requests. It also checks that the permission flag shows up alone when the page is inside its limit.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;

    typedef enum logic [1:0] {
        RGN_PROG = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_SYS  = 2'd2,
        RGN_RSVD = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } mode_e;

    typedef struct packed {
        logic len_bad;
        logic acc_bad;
    } fault_t;

    // The code holds two floors: the least privileged mode that may write
    // (upper half) and the least privileged mode that may read (lower half).
    // A write also needs read rights, so rights can never grow as privilege falls.
    function automatic logic prot_allows(input logic [1:0] mode,
                                         input logic       wr,
                                         input logic [3:0] code);
        logic rd_ok;
        logic wr_ok;
        rd_ok = (mode <= code[1:0]);
        wr_ok = rd_ok && (mode <= code[3:2]);
        return wr ? wr_ok : rd_ok;
    endfunction

endpackage

// File: rtl/vaddr_split.sv
module vaddr_split
    import vaddr_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 9,
    parameter int VPN_W = VA_W - 2 - OFF_W
) (
    input  logic [VA_W-1:0]  addr,
    output region_e          rgn,
    output logic [VPN_W-1:0] vpn,
    output logic [OFF_W-1:0] off
);
    localparam int RGN_LO = VA_W - 2;

    always_comb begin
        rgn = region_e'(addr[VA_W-1:RGN_LO]);
        vpn = addr[RGN_LO-1:OFF_W];
        off = addr[OFF_W-1:0];
    end

endmodule

// File: rtl/vaddr_len_check.sv
module vaddr_len_check
    import vaddr_pkg::*;
#(
    parameter int VPN_W = 21
) (
    input  region_e          rgn,
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0] lim_prog,
    input  logic [VPN_W-1:0] lim_ctrl,
    input  logic [VPN_W-1:0] lim_sys,
    output logic             len_bad
);
    logic below_prog;
    logic below_ctrl;
    logic below_sys;

    always_comb begin
        below_prog = (vpn < lim_prog);
        below_ctrl = (vpn < lim_ctrl);
        below_sys  = (vpn < lim_sys);
        unique case (rgn)
            RGN_PROG: len_bad = !below_prog;
            RGN_CTRL: len_bad = below_ctrl;  // grows downward: limit is a floor
            RGN_SYS:  len_bad = !below_sys;
            default:  len_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/vaddr_prot_check.sv
module vaddr_prot_check
    import vaddr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       wr,
    input  logic [3:0] code,
    output logic       allow
);
    always_comb begin
        allow = prot_allows(mode, wr, code);
    end

    // Higher privilege never has fewer rights than lower privilege on the same page
    always_comb begin
        if (mode != 2'd0) begin
            AST_MONOTONE_RIGHTS: assert (!allow || prot_allows(mode - 2'd1, wr, code)); // R6
        end
    end

endmodule

// File: rtl/vaddr_guard.sv
module vaddr_guard
    import vaddr_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 9,
    parameter int VPN_W = VA_W - 2 - OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VA_W-1:0]  in_addr,
    input  logic             in_write,
    input  logic [1:0]       in_mode,
    input  logic [3:0]       in_prot,
    input  logic [VPN_W-1:0] p0_len,
    input  logic [VPN_W-1:0] p1_len,
    input  logic [VPN_W-1:0] sys_len,
    output logic             out_valid,
    output logic [1:0]       out_region,
    output logic [VPN_W-1:0] out_vpn,
    output logic [OFF_W-1:0] out_offset,
    output logic             out_len_fault,
    output logic             out_acc_fault
);
    region_e          c_rgn;
    logic [VPN_W-1:0] c_vpn;
    logic [OFF_W-1:0] c_off;
    logic             c_len_bad;
    logic             c_allow;
    fault_t           c_fault;
    fault_t           r_fault;

    vaddr_split #(.VA_W(VA_W), .OFF_W(OFF_W), .VPN_W(VPN_W)) u_split (
        .addr (in_addr),
        .rgn  (c_rgn),
        .vpn  (c_vpn),
        .off  (c_off)
    );

    vaddr_len_check #(.VPN_W(VPN_W)) u_len (
        .rgn      (c_rgn),
        .vpn      (c_vpn),
        .lim_prog (p0_len),
        .lim_ctrl (p1_len),
        .lim_sys  (sys_len),
        .len_bad  (c_len_bad)
    );

    vaddr_prot_check u_prot (
        .mode  (in_mode),
        .wr    (in_write),
        .code  (in_prot),
        .allow (c_allow)
    );

    always_comb begin
        c_fault.len_bad = c_len_bad;
        c_fault.acc_bad = !c_len_bad && !c_allow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            r_fault    <= '0;
            out_region <= '0;
            out_vpn    <= '0;
            out_offset <= '0;
        end else begin
            out_valid <= in_valid;
            r_fault   <= in_valid ? c_fault : '0;
            if (in_valid) begin
                out_region <= c_rgn;
                out_vpn    <= c_vpn;
                out_offset <= c_off;
            end
        end
    end

    assign out_len_fault = r_fault.len_bad;
    assign out_acc_fault = r_fault.acc_bad;

    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(out_len_fault && out_acc_fault)); // R7
    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R8
    AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_len_fault && !out_acc_fault)); // R8
    AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_region == 2'd3) |-> out_len_fault); // R5
    AST_OFFSET_CARRIED: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_offset == $past(in_addr[OFF_W-1:0]))); // R1
    AST_REGION_CARRIED: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_region == $past(in_addr[VA_W-1:VA_W-2]))); // R2

endmodule

// File: tb/vaddr_guard_tb.sv
module vaddr_guard_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_addr;
    logic        in_write;
    logic [1:0]  in_mode;
    logic [3:0]  in_prot;
    logic [20:0] p0_len, p1_len, sys_len;
    logic        out_valid;
    logic [1:0]  out_region;
    logic [20:0] out_vpn;
    logic [8:0]  out_offset;
    logic        out_len_fault, out_acc_fault;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    vaddr_guard u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_write(in_write), .in_mode(in_mode), .in_prot(in_prot),
        .p0_len(p0_len), .p1_len(p1_len), .sys_len(sys_len),
        .out_valid(out_valid), .out_region(out_region), .out_vpn(out_vpn),
        .out_offset(out_offset), .out_len_fault(out_len_fault),
        .out_acc_fault(out_acc_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic one_req(input logic [1:0] rgn, input logic [20:0] vpn, input logic [8:0] off,
                           input logic wr, input logic [1:0] mode, input logic [3:0] prot);
        logic lbad, rd_ok, ok, abad;
        @(negedge clk);
        in_addr  = {rgn, vpn, off};
        in_write = wr;
        in_mode  = mode;
        in_prot  = prot;
        in_valid = 1'b1;
        case (rgn)
            2'd0:    lbad = (vpn >= p0_len);   // R3
            2'd1:    lbad = (vpn < p1_len);    // R4
            2'd2:    lbad = (vpn >= sys_len);  // R3
            default: lbad = 1'b1;              // R5
        endcase
        rd_ok = (mode <= prot[1:0]);
        ok    = wr ? (rd_ok && (mode <= prot[3:2])) : rd_ok;
        abad  = !lbad && !ok;                  // R6, R7
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 valid", {31'd0, out_valid}, 32'd1);
        check("R2 region", {30'd0, out_region}, {30'd0, rgn});
        check("R1 vpn", {11'd0, out_vpn}, {11'd0, vpn});
        check("R1 offset", {23'd0, out_offset}, {23'd0, off});
        if (rgn == 2'd3) check("R5 len", {31'd0, out_len_fault}, 32'd1);
        else if (rgn == 2'd1) check("R4 len", {31'd0, out_len_fault}, {31'd0, lbad});
        else check("R3 len", {31'd0, out_len_fault}, {31'd0, lbad});
        check("R6 R7 acc", {31'd0, out_acc_fault}, {31'd0, abad});
        @(negedge clk);
        check("R8 pulse", {29'd0, out_valid, out_len_fault, out_acc_fault}, 32'd0);
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_addr = 32'hFFFF_FFFF; in_write = 1'b1;
        in_mode = 2'd3; in_prot = 4'd0;
        p0_len = 21'd5; p1_len = 21'd5; sys_len = 21'd5;
        repeat (3) @(negedge clk);
        // R9: reset holds outputs low despite an active request
        check("R9 reset", {29'd0, out_valid, out_len_fault, out_acc_fault}, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R9 after reset", {29'd0, out_valid, out_len_fault, out_acc_fault}, 32'd0);

        // Main sweep: both faults often possible on the same request (R7)
        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 4; m++)
                for (int p = 0; p < 16; p++)
                    for (int w = 0; w < 2; w++)
                        for (int v = 4; v < 7; v++)
                            one_req(r[1:0], v[20:0], 9'((r * 97 + p * 31 + v * 7 + m) & 511),
                                    w[0], m[1:0], p[3:0]);

        // Limit boundaries: zero limits (R3, R4), large page numbers
        p0_len = 21'd0; p1_len = 21'd0; sys_len = 21'd0;
        for (int r = 0; r < 4; r++) begin
            one_req(r[1:0], 21'd0, 9'd0, 1'b0, 2'd0, 4'hF);
            one_req(r[1:0], 21'h1F_FFFF, 9'h1FF, 1'b1, 2'd3, 4'hF);
        end
        p0_len = 21'h1F_FFFF; p1_len = 21'h1F_FFFF; sys_len = 21'h1F_FFFF;
        for (int r = 0; r < 4; r++) begin
            one_req(r[1:0], 21'h1F_FFFE, 9'd1, 1'b0, 2'd1, 4'h5);
            one_req(r[1:0], 21'h1F_FFFF, 9'd2, 1'b1, 2'd2, 4'hA);
        end

        // Back-to-back requests: valid stays high on consecutive results (R8)
        p0_len = 21'd8;
        @(negedge clk);
        in_valid = 1'b1; in_addr = {2'd0, 21'd3, 9'd4}; in_write = 1'b0; in_mode = 2'd0; in_prot = 4'd0;
        @(negedge clk);
        check("R8 first", {30'd0, out_valid, out_len_fault}, 32'd2);
        in_addr = {2'd0, 21'd9, 9'd5};
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 second", {30'd0, out_valid, out_len_fault}, 32'd3);
        check("R1 second", {23'd0, out_offset}, 32'd5);
        @(negedge clk);
        check("R8 end", {31'd0, out_valid}, 32'd0);

        // Reset during an accepted request (R9)
        in_valid = 1'b1; in_addr = {2'd3, 21'd0, 9'd0};
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid reset", {29'd0, out_valid, out_len_fault, out_acc_fault}, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule